// File: doc/BRIEF.md
# PLL Frequency Setting Calculator

This block turns a desired output clock frequency into the settings of a fractional-N PLL, and turns PLL settings back into the output frequency they produce. The settings are a fixed-point feedback word, whose integer part has a configurable width and whose remaining low bits are fractional, and a post-divider that is a power of two. In the forward direction the caller supplies the wanted frequency, an upper limit on that frequency, the lowest VCO frequency the PLL can run at, the reference frequency and the field widths. The block then picks the post-divider and computes the feedback word. In the reverse direction the caller supplies the reference, the feedback word and the post-divider code, and gets back the output frequency. The result is rounded upward in two places.

A pulse on `start` while the block is idle captures every input. The block runs a bit-serial divider in the forward direction and a bit-serial multiplier in the reverse direction. It then pulses `done` for one cycle. Its result outputs hold their values until the next operation of the same direction completes. A zero reference ends the operation early with an error flag and leaves the results untouched.

Top module: `pll_freq_calc`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, and `pcw_out`, `pdiv_out` and `freq_out` are zero.
- R2: `start` is taken only while `busy` is low. A forward operation (`dir`=0) keeps `busy` high for 66 cycles and a reverse operation (`dir`=1) for 34 cycles. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R3: A `start` pulse while `busy` is high has no effect. Input changes after an accepted `start` do not change that operation's result.
- R4: If the captured `ref_freq` is zero, `busy` stays high for one cycle, then `done` pulses with `err`=1, and `pcw_out`, `pdiv_out` and `freq_out` keep their previous values.
- R5: In the forward direction the working frequency f is `req_freq` clamped to at most `max_freq`.
- R6: The forward search takes the smallest k in 0..4 with f·2^k ≥ the VCO minimum, and `pdiv_out` = k (the post-divider is 2^`pdiv_out`). If no k qualifies, `pdiv_out` = 4, but the feedback word is computed with k = 5.
- R7: A `vco_min` of zero means a VCO minimum of 1,000,000,000.
- R8: The integer width is `int_width`, or 7 when `int_width` is zero. The fractional width is `pcw_width` minus the integer width when `pcw_width` is larger, and zero otherwise.
- R9: `pcw_out` is the low 32 bits of floor(D / `ref_freq`), where D is ((f shifted left by k) shifted left by the fractional width), kept to 64 bits.
- R10: In the reverse direction the feedback word is `pcw_in` masked to its low `pcw_width` bits. vco = `ref_freq` × word, shifted right by the fractional width, plus one if any bit shifted out was set.
- R11: `freq_out` is the low 32 bits of ceil(vco / 2^`pdiv_in`), for `pdiv_in` from 0 to 7.
- R12: A forward operation changes only `pcw_out` and `pdiv_out`, and a reverse operation changes only `freq_out`. A successful operation clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (taken only when idle) |
| dir | input | 1 | 0 = frequency to settings, 1 = settings to frequency |
| ref_freq | input | 32 | Reference frequency |
| req_freq | input | 32 | Wanted output frequency (forward) |
| max_freq | input | 32 | Upper limit on the output frequency (forward) |
| vco_min | input | 32 | Lowest VCO frequency, 0 selects the default (forward) |
| pcw_width | input | 6 | Total feedback word width, 0 to 32 |
| int_width | input | 6 | Integer part width, 0 selects 7 |
| pcw_in | input | 32 | Feedback word (reverse) |
| pdiv_in | input | 3 | Post-divider log2 code (reverse) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation had a zero reference |
| pcw_out | output | 32 | Computed feedback word |
| pdiv_out | output | 3 | Computed post-divider log2 code |
| freq_out | output | 32 | Computed output frequency |

## Verification
A wrong internal state shows up at the ports in one of three ways: a wrong result value, a `done` pulse that arrives early or late, or a result that changes outside its `done` cycle. A bad iteration counter or a bad state transition changes how long `busy` stays high, and the cycle-accurate model compares `busy` and `done` on every clock. A corrupted divider or multiplier register, or a wrong shift or rounding term, gives a wrong value, and this is caught in the single cycle in which `done` is high.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  // number of post-divider candidates: 2^0 .. 2^4
  localparam int PD_STEPS        = 5;
  localparam int INT_W_DEFAULT   = 7;
  localparam int VCO_MIN_DEFAULT = 1_000_000_000;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_FIN   = 2'd3
  } calc_state_e;

endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 32,
  parameter int Q_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [Q_W-1:0]   quotient
);

  logic [DVD_W-1:0] quo_q, quo_d;
  logic [DVS_W-1:0] rem_q, rem_d;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             en;

  assign trial = {rem_q, quo_q[DVD_W-1]};
  assign diff  = trial - {1'b0, divisor};
  assign en    = load | step;

  always_comb begin
    quo_d = quo_q;
    rem_d = rem_q;
    if (load) begin
      quo_d = dividend;
      rem_d = '0;
    end else if (step) begin
      // top bit of diff set means the trial value was below the divisor
      if (diff[DVS_W]) begin
        rem_d = trial[DVS_W-1:0];
      end else begin
        rem_d = diff[DVS_W-1:0];
      end
      quo_d = {quo_q[DVD_W-2:0], ~diff[DVS_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
    end else if (en) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
    end
  end

  assign quotient = quo_q[Q_W-1:0];

endmodule

// File: rtl/pll_shift_mult.sv
module pll_shift_mult #(
  parameter int A_W = 32,
  parameter int B_W = 32,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [P_W-1:0] prod
);

  logic [P_W-1:0] prod_q, prod_d;
  logic [A_W:0]   sum;
  logic [A_W-1:0] addend;
  logic           en;

  assign addend = prod_q[0] ? a : '0;
  assign sum    = {1'b0, prod_q[P_W-1:B_W]} + {1'b0, addend};
  assign en     = load | step;

  always_comb begin
    prod_d = prod_q;
    if (load) begin
      prod_d = {{A_W{1'b0}}, b};
    end else if (step) begin
      prod_d = {sum, prod_q[B_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (en) begin
      prod_q <= prod_d;
    end
  end

  assign prod = prod_q;

endmodule

// File: rtl/pll_fwd_prep.sv
module pll_fwd_prep
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int WIDE_W = 64,
  parameter int WID_W  = 6,
  parameter int PDIV_W = 3,
  localparam int K_W   = $clog2(PD_STEPS + 1)
) (
  input  logic [FREQ_W-1:0] req_freq,
  input  logic [FREQ_W-1:0] max_freq,
  input  logic [FREQ_W-1:0] vco_min,
  input  logic [WID_W-1:0]  pcw_width,
  input  logic [WID_W-1:0]  int_width,
  output logic [WIDE_W-1:0] dividend,
  output logic [PDIV_W-1:0] pdiv_code,
  output logic [WID_W-1:0]  frac_bits
);

  logic [FREQ_W-1:0]   f_clamp;
  logic [FREQ_W-1:0]   vmin_eff;
  logic [WID_W-1:0]    int_eff;
  logic [PD_STEPS-1:0] reach;
  logic [K_W-1:0]      k_sel;

  assign f_clamp  = (req_freq > max_freq) ? max_freq : req_freq;
  assign vmin_eff = (vco_min == '0) ? FREQ_W'(VCO_MIN_DEFAULT) : vco_min;
  assign int_eff  = (int_width == '0) ? WID_W'(INT_W_DEFAULT) : int_width;
  assign frac_bits = (pcw_width > int_eff) ? (pcw_width - int_eff) : '0;

  for (genvar g = 0; g < PD_STEPS; g++) begin : g_cand
    assign reach[g] = ((WIDE_W'(f_clamp) << g) >= WIDE_W'(vmin_eff));
  end

  always_comb begin
    k_sel = K_W'(PD_STEPS);
    for (int i = PD_STEPS - 1; i >= 0; i--) begin
      if (reach[i]) begin
        k_sel = K_W'(i);
      end
    end
  end

  assign pdiv_code = (k_sel == K_W'(PD_STEPS)) ? PDIV_W'(PD_STEPS - 1) : PDIV_W'(k_sel);
  assign dividend  = (WIDE_W'(f_clamp) << k_sel) << frac_bits;

endmodule

// File: rtl/pll_rev_round.sv
module pll_rev_round #(
  parameter int FREQ_W = 32,
  parameter int WIDE_W = 64,
  parameter int WID_W  = 6,
  parameter int PDIV_W = 3
) (
  input  logic [WIDE_W-1:0] vco_raw,
  input  logic [WID_W-1:0]  frac_bits,
  input  logic [PDIV_W-1:0] pdiv_code,
  output logic [FREQ_W-1:0] freq
);

  logic [WIDE_W-1:0] frac_mask;
  logic [WIDE_W-1:0] pd_mask;
  logic [WIDE_W-1:0] vco_int;
  logic              lost_frac;
  logic              lost_pd;

  assign frac_mask = (WIDE_W'(1) << frac_bits) - WIDE_W'(1);
  assign lost_frac = |(vco_raw & frac_mask);
  assign vco_int   = (vco_raw >> frac_bits) + WIDE_W'(lost_frac);

  assign pd_mask   = (WIDE_W'(1) << pdiv_code) - WIDE_W'(1);
  assign lost_pd   = |(vco_int & pd_mask);
  assign freq      = FREQ_W'(vco_int >> pdiv_code) + FREQ_W'(lost_pd);

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int PCW_W  = 32,
  parameter int PDIV_W = 3,
  localparam int WID_W = $clog2(PCW_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [FREQ_W-1:0] ref_freq,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic [FREQ_W-1:0] max_freq,
  input  logic [FREQ_W-1:0] vco_min,
  input  logic [WID_W-1:0]  pcw_width,
  input  logic [WID_W-1:0]  int_width,
  input  logic [PCW_W-1:0]  pcw_in,
  input  logic [PDIV_W-1:0] pdiv_in,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [PCW_W-1:0]  pcw_out,
  output logic [PDIV_W-1:0] pdiv_out,
  output logic [FREQ_W-1:0] freq_out
);

  localparam int WIDE_W = FREQ_W + PCW_W;
  localparam int CNT_W  = $clog2(WIDE_W);
  localparam logic [CNT_W-1:0] LAST_DIV = CNT_W'(WIDE_W - 1);
  localparam logic [CNT_W-1:0] LAST_MUL = CNT_W'(PCW_W - 1);

  logic rst_i_n;

  calc_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cap_en;
  logic             eng_load, eng_step;
  logic             done_d, err_d;
  logic             upd_fwd, upd_rev;

  logic              c_dir;
  logic [FREQ_W-1:0] c_ref, c_req, c_max, c_vmin;
  logic [WID_W-1:0]  c_pw, c_iw;
  logic [PCW_W-1:0]  c_pcw;
  logic [PDIV_W-1:0] c_pd;

  logic              done_q, err_q;
  logic [PCW_W-1:0]  pcw_q;
  logic [PDIV_W-1:0] pd_q;
  logic [FREQ_W-1:0] freq_q;

  logic [WIDE_W-1:0] dividend;
  logic [PDIV_W-1:0] fwd_code;
  logic [WID_W-1:0]  frac_bits;
  logic [PCW_W-1:0]  pcw_mask;
  logic [PCW_W-1:0]  pcw_word;
  logic [PCW_W-1:0]  quo;
  logic [WIDE_W-1:0] prod;
  logic [FREQ_W-1:0] rev_freq;

  pll_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // ---------------- control: next state ----------------
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cap_en   = 1'b0;
    eng_load = 1'b0;
    eng_step = 1'b0;
    done_d   = 1'b0;
    err_d    = err_q;
    upd_fwd  = 1'b0;
    upd_rev  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          cap_en = 1'b1;
          st_d   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (c_ref == '0) begin
          done_d = 1'b1;
          err_d  = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          eng_load = 1'b1;
          cnt_d    = '0;
          st_d     = ST_RUN;
        end
      end
      ST_RUN: begin
        eng_step = 1'b1;
        if (cnt_q == (c_dir ? LAST_MUL : LAST_DIV)) begin
          st_d = ST_FIN;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_FIN: begin
        done_d  = 1'b1;
        err_d   = 1'b0;
        upd_fwd = ~c_dir;
        upd_rev = c_dir;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // ---------------- control: registers ----------------
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // ---------------- operand capture ----------------
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      c_dir  <= 1'b0;
      c_ref  <= '0;
      c_req  <= '0;
      c_max  <= '0;
      c_vmin <= '0;
      c_pw   <= '0;
      c_iw   <= '0;
      c_pcw  <= '0;
      c_pd   <= '0;
    end else if (cap_en) begin
      c_dir  <= dir;
      c_ref  <= ref_freq;
      c_req  <= req_freq;
      c_max  <= max_freq;
      c_vmin <= vco_min;
      c_pw   <= pcw_width;
      c_iw   <= int_width;
      c_pcw  <= pcw_in;
      c_pd   <= pdiv_in;
    end
  end

  // ---------------- datapath ----------------
  pll_fwd_prep #(
    .FREQ_W (FREQ_W),
    .WIDE_W (WIDE_W),
    .WID_W  (WID_W),
    .PDIV_W (PDIV_W)
  ) u_prep (
    .req_freq  (c_req),
    .max_freq  (c_max),
    .vco_min   (c_vmin),
    .pcw_width (c_pw),
    .int_width (c_iw),
    .dividend  (dividend),
    .pdiv_code (fwd_code),
    .frac_bits (frac_bits)
  );

  assign pcw_mask = (c_pw >= WID_W'(PCW_W)) ? '1 : ((PCW_W'(1) << c_pw) - PCW_W'(1));
  assign pcw_word = c_pcw & pcw_mask;

  pll_restoring_div #(
    .DVD_W (WIDE_W),
    .DVS_W (FREQ_W),
    .Q_W   (PCW_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (eng_load & ~c_dir),
    .step     (eng_step & ~c_dir),
    .dividend (dividend),
    .divisor  (c_ref),
    .quotient (quo)
  );

  pll_shift_mult #(
    .A_W (FREQ_W),
    .B_W (PCW_W)
  ) u_mul (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (eng_load & c_dir),
    .step  (eng_step & c_dir),
    .a     (c_ref),
    .b     (pcw_word),
    .prod  (prod)
  );

  pll_rev_round #(
    .FREQ_W (FREQ_W),
    .WIDE_W (WIDE_W),
    .WID_W  (WID_W),
    .PDIV_W (PDIV_W)
  ) u_round (
    .vco_raw   (prod),
    .frac_bits (frac_bits),
    .pdiv_code (c_pd),
    .freq      (rev_freq)
  );

  // ---------------- result registers ----------------
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pcw_q <= '0;
      pd_q  <= '0;
    end else if (upd_fwd) begin
      pcw_q <= quo;
      pd_q  <= fwd_code;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      freq_q <= '0;
    end else if (upd_rev) begin
      freq_q <= rev_freq;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign pcw_out  = pcw_q;
  assign pdiv_out = pd_q;
  assign freq_out = freq_q;

endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int PCW_W  = 32,
  parameter int PDIV_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [PCW_W-1:0]  pcw_out,
  input logic [PDIV_W-1:0] pdiv_out,
  input logic [FREQ_W-1:0] freq_out
);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R12
  results_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pcw_out) && $stable(pdiv_out) && $stable(freq_out) && $stable(err)));

  // R4
  err_keeps_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($stable(pcw_out) && $stable(pdiv_out) && $stable(freq_out)));

  // R6
  pdiv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdiv_out <= PDIV_W'(PD_STEPS - 1));

endmodule

bind pll_freq_calc pll_freq_calc_chk #(
  .FREQ_W (FREQ_W),
  .PCW_W  (PCW_W),
  .PDIV_W (PDIV_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .pcw_out  (pcw_out),
  .pdiv_out (pdiv_out),
  .freq_out (freq_out)
);

// File: tb/sim_pll_freq_calc.sv
module sim_pll_freq_calc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir = 1'b0;
  logic [31:0] ref_freq = '0, req_freq = '0, max_freq = '0, vco_min = '0;
  logic [5:0]  pcw_width = '0, int_width = '0;
  logic [31:0] pcw_in = '0;
  logic [2:0]  pdiv_in = '0;
  logic        busy, done, err;
  logic [31:0] pcw_out, freq_out;
  logic [2:0]  pdiv_out;

  always #4 clk = ~clk;

  pll_freq_calc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
    .ref_freq(ref_freq), .req_freq(req_freq), .max_freq(max_freq), .vco_min(vco_min),
    .pcw_width(pcw_width), .int_width(int_width), .pcw_in(pcw_in), .pdiv_in(pdiv_in),
    .busy(busy), .done(done), .err(err),
    .pcw_out(pcw_out), .pdiv_out(pdiv_out), .freq_out(freq_out)
  );

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    finished = 0;
  string tag = "R1";

  // ---------------- behavioural reference model ----------------
  bit          m_busy, m_done, m_err;
  logic [31:0] m_pcw, m_freq;
  logic [2:0]  m_pd;
  int          m_cnt;
  bit          p_fwd, p_err;
  logic [31:0] p_pcw, p_freq;
  logic [2:0]  p_pd;

  function automatic int frac_of(int pw, int iw);
    int ie = (iw == 0) ? 7 : iw;
    return (pw > ie) ? pw - ie : 0;
  endfunction

  function automatic void model_fwd(longint unsigned rf, longint unsigned rq, longint unsigned mx,
                                    longint unsigned vm, int pw, int iw,
                                    output logic [31:0] pcw, output logic [2:0] pd);
    longint unsigned f = (rq > mx) ? mx : rq;
    longint unsigned vmin = (vm == 0) ? 64'd1000000000 : vm;
    longint unsigned dvd;
    int k = 0;
    while (k < 5 && (f << k) < vmin) k++;
    dvd = (f << k) << frac_of(pw, iw);
    pcw = 32'(dvd / rf);
    pd  = 3'((k > 4) ? 4 : k);
  endfunction

  function automatic logic [31:0] model_rev(longint unsigned rf, longint unsigned pc, int pw, int iw, int code);
    longint unsigned word = (pw >= 32) ? pc : (pc & ((64'd1 << pw) - 1));
    longint unsigned vco = rf * word;
    int fr = frac_of(pw, iw);
    longint unsigned v;
    longint unsigned pdv = 64'd1 << code;
    v = vco >> fr;
    if (fr > 0 && (vco % (64'd1 << fr)) != 0) v = v + 1;
    return 32'(v / pdv + (((v % pdv) != 0) ? 64'd1 : 64'd0));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
      m_pcw = '0; m_pd = '0; m_freq = '0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          m_done = 1;
          m_err  = p_err;
          if (!p_err) begin
            if (p_fwd) begin
              m_pcw = p_pcw;
              m_pd  = p_pd;
            end else begin
              m_freq = p_freq;
            end
          end
        end
      end else if (start) begin
        m_busy = 1;
        p_fwd  = !dir;
        p_err  = (ref_freq == 0);
        if (p_err) begin
          m_cnt = 1;
        end else if (!dir) begin
          model_fwd(ref_freq, req_freq, max_freq, vco_min, pcw_width, int_width, p_pcw, p_pd);
          m_cnt = 66;
        end else begin
          p_freq = model_rev(ref_freq, pcw_in, pcw_width, int_width, pdiv_in);
          m_cnt = 34;
        end
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (busy !== m_busy || done !== m_done || err !== m_err ||
          pcw_out !== m_pcw || pdiv_out !== m_pd || freq_out !== m_freq) begin
        fails++;
        $display("FAIL %s cycle %0d: actual busy=%b done=%b err=%b pcw=%0d pd=%0d freq=%0d expected busy=%b done=%b err=%b pcw=%0d pd=%0d freq=%0d",
                 tag, cyc, busy, done, err, pcw_out, pdiv_out, freq_out,
                 m_busy, m_done, m_err, m_pcw, m_pd, m_freq);
      end
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL R2 watchdog: actual no completion after %0d cycles expected done", cyc);
      finish_up();
    end
  end

  task automatic chk(string t, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  // start an operation at a falling edge and wait for done; returns busy length
  task automatic run_op(bit d, logic [31:0] rf, logic [31:0] rq, logic [31:0] mx, logic [31:0] vm,
                        int pw, int iw, logic [31:0] pc, int code, output int blen);
    dir = d; ref_freq = rf; req_freq = rq; max_freq = mx; vco_min = vm;
    pcw_width = 6'(pw); int_width = 6'(iw); pcw_in = pc; pdiv_in = 3'(code);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    blen = 0;
    if (busy) blen++;
    while (!done) begin
      @(negedge clk);
      if (busy) blen++;
    end
  endtask

  initial begin
    int bl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    tag = "R1";
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 pcw_out", pcw_out, 0);
    chk("R1 pdiv_out", pdiv_out, 0);
    chk("R1 freq_out", freq_out, 0);

    tag = "R9";
    run_op(0, 26_000_000, 1_500_000_000, 32'd3_000_000_000, 0, 22, 0, 0, 0, bl);
    chk("R2 forward busy cycles", bl, 66);
    chk("R9 pcw fractional", pcw_out, 1890461);
    chk("R9 pdiv", pdiv_out, 0);

    tag = "R10";
    run_op(1, 26_000_000, 0, 0, 0, 22, 0, 1890461, 0, bl);
    chk("R2 reverse busy cycles", bl, 34);
    chk("R10 freq with frac round-up", freq_out, 1499999573);
    chk("R12 pcw kept by reverse", pcw_out, 1890461);

    tag = "R5";
    run_op(0, 1_000_000, 32'd4_000_000_000, 2_000_000_000, 0, 7, 7, 0, 0, bl);
    chk("R5 clamped pcw", pcw_out, 2000);
    chk("R12 freq kept by forward", freq_out, 1499999573);

    tag = "R6";
    run_op(0, 1_000_000, 300_000_000, 32'd3_000_000_000, 0, 7, 0, 0, 0, bl);
    chk("R6 pdiv smallest k", pdiv_out, 2);
    chk("R7 default vco min pcw", pcw_out, 1200);

    run_op(0, 1_000_000, 10_000_000, 32'd3_000_000_000, 0, 7, 0, 0, 0, bl);
    chk("R6 none qualifies pdiv", pdiv_out, 4);
    chk("R6 none qualifies pcw uses k=5", pcw_out, 320);

    tag = "R7";
    run_op(0, 1_000_000, 300_000_000, 32'd3_000_000_000, 500_000_000, 7, 0, 0, 0, bl);
    chk("R7 explicit vco min pdiv", pdiv_out, 1);
    chk("R7 explicit vco min pcw", pcw_out, 600);

    tag = "R8";
    run_op(0, 25_000_000, 1_200_000_000, 32'd3_000_000_000, 0, 10, 4, 0, 0, bl);
    chk("R8 explicit int width", pcw_out, 3072);
    run_op(0, 10_000_000, 1_000_000_000, 32'd3_000_000_000, 0, 5, 0, 0, 0, bl);
    chk("R8 word narrower than int part", pcw_out, 100);

    tag = "R11";
    run_op(1, 7, 0, 0, 0, 8, 0, 32'h123, 3, bl);
    chk("R10 masked word and R11 ceiling", freq_out, 16);
    run_op(1, 1000, 0, 0, 0, 32, 32, 1000, 7, bl);
    chk("R11 code 7 ceiling", freq_out, 7813);

    tag = "R4";
    run_op(0, 0, 123, 456, 0, 22, 0, 0, 0, bl);
    chk("R4 zero ref busy cycles", bl, 1);
    chk("R4 err flag", err, 1);
    chk("R4 pcw unchanged", pcw_out, 100);
    chk("R4 freq unchanged", freq_out, 7813);

    tag = "R12";
    run_op(1, 1000, 0, 0, 0, 32, 32, 1000, 7, bl);
    chk("R12 err cleared by success", err, 0);

    // start pulses while busy must be ignored, late input changes too
    tag = "R3";
    dir = 0; ref_freq = 1_000_000; req_freq = 300_000_000; max_freq = 32'd3_000_000_000;
    vco_min = 0; pcw_width = 7; int_width = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    req_freq = 700_000_000; ref_freq = 3; dir = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R3 result from first start", pcw_out, 1200);
    @(negedge clk);
    chk("R3 no second operation", busy, 0);

    // randomised operands, checked by the per-cycle model
    for (int i = 0; i < 40; i++) begin
      if (i % 2 == 0) begin
        tag = "R9 random";
        run_op(0, $urandom | 32'd1, $urandom, $urandom, (i % 4 == 0) ? 32'd0 : $urandom,
               int'($urandom_range(1, 32)), int'($urandom_range(0, 31)), 0, 0, bl);
      end else begin
        tag = "R10 random";
        run_op(1, $urandom | 32'd1, 0, 0, 0, int'($urandom_range(0, 32)),
               int'($urandom_range(0, 31)), $urandom, int'($urandom_range(0, 7)), bl);
      end
    end

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule